// File: doc/BRIEF.md
# Processor Trap Entry Sequencer

This block makes the state changes a register-windowed processor applies when it takes a trap. The surrounding pipeline supplies the current program counter pair, the status bits, the window pointer, the interrupt level and the trap base address. It also supplies a trap request with a type code, a synchronous/asynchronous flag and a reset request. On the clock edge where a trap is accepted, the sequencer registers the new status bits, the rotated window pointer, the trap base register image and the new PC/nPC vector. It also registers the two return values destined for the first two locals of the new window, and whether the instruction in execute is allowed to complete.

Only reversible changes are made to the status word. The enable bit is cleared, the supervisor bit is copied into the previous-supervisor bit and the window pointer rotates down. The status word is not saved, and the interrupt level passes through unchanged. A synchronous trap raised while traps are disabled does not vector. Instead it drives the block into an error mode that only a reset request leaves.

Top module: `trap_entry_seq`

## Requirements
- R1: On an accepted trap, the registered enable bit `nxt_et_o` is 0 and `nxt_ps_o` equals the `cur_s` value sampled at acceptance.
- R2: On an accepted trap, `nxt_cwp_o` is `cur_cwp - 1`, with 0 wrapping to `NWIN-1`. This holds for window counts that are not powers of two.
- R3: On an accepted trap, `tbr_o` is `{tbr_base, tt, 4'b0000}`, with the base in bits 31:12 and tt in bits 11:4. tt is `trap_code` for a non-reset trap and 8'h00 for a reset.
- R4: A non-reset trap sets `pc_o` to the `tbr_o` value and `npc_o` to that value plus 4. A reset sets `pc_o` to 0 and `npc_o` to 4.
- R5: A synchronous trap (`trap_sync`=1) saves `cur_pc` in `save0_o` and `cur_npc` in `save1_o`, and drives `ex_commit_o` to 0. A reset saves the same pair, also with `ex_commit_o` 0.
- R6: An asynchronous trap (`trap_sync`=0) saves `cur_npc` in `save0_o` and `cur_npc + 4` in `save1_o`, and drives `ex_commit_o` to 1.
- R7: While `cur_et` is 0, an asynchronous request is ignored. `take_o` stays 0 and every registered output keeps its value.
- R8: A synchronous request while `cur_et` is 0 sets `err_mode_o` one cycle later and does not vector (`take_o` 0). Error mode persists, and every non-reset request is ignored while it is set.
- R9: On an accepted trap, `nxt_pil_o` equals the sampled `cur_pil`. The level is never altered.
- R10: `reset_req` is accepted whatever `cur_et`, `err_mode_o` or `trap_req` are, wins over any simultaneous trap request, and clears error mode.
- R11: `take_o` is high for exactly the one cycle after each accepted trap, and at most one trap is accepted per cycle. Between acceptances all vector and status outputs hold.
- R12: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_req | input | 1 | Trap request this cycle |
| trap_sync | input | 1 | 1 = synchronous trap, 0 = asynchronous |
| trap_code | input | TTW | Trap type code |
| reset_req | input | 1 | Reset trap request, highest priority |
| cur_pc | input | XLEN | PC before the trap |
| cur_npc | input | XLEN | nPC before the trap |
| cur_et | input | 1 | Current trap enable bit |
| cur_s | input | 1 | Current supervisor bit |
| cur_cwp | input | CWPW | Current window pointer, below NWIN |
| cur_pil | input | 4 | Current interrupt level |
| tbr_base | input | XLEN-TTW-4 | Trap table base address |
| take_o | output | 1 | Pulse: a trap was accepted on the previous edge |
| err_mode_o | output | 1 | Error mode held |
| ex_commit_o | output | 1 | Instruction in execute completes (asynchronous entry) |
| nxt_et_o | output | 1 | New trap enable bit |
| nxt_ps_o | output | 1 | New previous-supervisor bit |
| nxt_cwp_o | output | CWPW | New window pointer |
| nxt_pil_o | output | 4 | Interrupt level, unchanged |
| tbr_o | output | XLEN | Trap base register image |
| pc_o | output | XLEN | New PC |
| npc_o | output | XLEN | New nPC |
| save0_o | output | XLEN | Return value for first local of new window |
| save1_o | output | XLEN | Return value for second local of new window |

## Verification
The assertions assume that `cur_cwp` always holds a legal window index below `NWIN`, and that all inputs are stable across each rising edge. They also assume the status inputs reflect the processor's state at the moment of the request. The stimulus draws the window pointer modulo a six-window configuration, so wrap from 0 to 5 is reachable, and drives every input only on the falling edge. Request, sync flag, enable and reset are drawn with biases chosen so that error mode is entered and left many times. Those biases also make simultaneous reset and trap requests common.

// File: rtl/trap_entry_seq.sv
module trap_entry_seq #(
  parameter int NWIN = 8,
  parameter int XLEN = 32,
  parameter int TTW  = 8,
  localparam int CWPW  = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int BASEW = XLEN - TTW - 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_req,
  input  logic             trap_sync,
  input  logic [TTW-1:0]   trap_code,
  input  logic             reset_req,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [XLEN-1:0]  cur_npc,
  input  logic             cur_et,
  input  logic             cur_s,
  input  logic [CWPW-1:0]  cur_cwp,
  input  logic [3:0]       cur_pil,
  input  logic [BASEW-1:0] tbr_base,
  output logic             take_o,
  output logic             err_mode_o,
  output logic             ex_commit_o,
  output logic             nxt_et_o,
  output logic             nxt_ps_o,
  output logic [CWPW-1:0]  nxt_cwp_o,
  output logic [3:0]       nxt_pil_o,
  output logic [XLEN-1:0]  tbr_o,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  npc_o,
  output logic [XLEN-1:0]  save0_o,
  output logic [XLEN-1:0]  save1_o
);

  logic err_q;
  assign err_mode_o = err_q;

  wire rst_acc  = reset_req;
  wire trap_acc = trap_req & cur_et & ~err_q & ~reset_req;
  wire err_set  = trap_req & trap_sync & ~cur_et & ~err_q & ~reset_req;
  wire accept   = rst_acc | trap_acc;
  wire keep_pair = rst_acc | trap_sync;

  wire [CWPW-1:0] cwp_dec = (cur_cwp == '0) ? CWPW'(NWIN - 1) : cur_cwp - 1'b1;
  wire [TTW-1:0]  tt_w    = rst_acc ? '0 : trap_code;
  wire [XLEN-1:0] tbr_w   = {tbr_base, tt_w, 4'b0000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o      <= 1'b0;
      err_q       <= 1'b0;
      ex_commit_o <= 1'b0;
      nxt_et_o    <= 1'b0;
      nxt_ps_o    <= 1'b0;
      nxt_cwp_o   <= '0;
      nxt_pil_o   <= '0;
      tbr_o       <= '0;
      pc_o        <= '0;
      npc_o       <= '0;
      save0_o     <= '0;
      save1_o     <= '0;
    end else begin
      take_o <= accept;
      if (rst_acc)      err_q <= 1'b0;
      else if (err_set) err_q <= 1'b1;
      if (accept) begin
        ex_commit_o <= ~keep_pair;
        nxt_et_o    <= 1'b0;
        nxt_ps_o    <= cur_s;
        nxt_cwp_o   <= cwp_dec;
        nxt_pil_o   <= cur_pil;
        tbr_o       <= tbr_w;
        pc_o        <= rst_acc ? '0 : tbr_w;
        npc_o       <= rst_acc ? XLEN'(4) : tbr_w + XLEN'(4);
        save0_o     <= keep_pair ? cur_pc  : cur_npc;
        save1_o     <= keep_pair ? cur_npc : cur_npc + XLEN'(4);
      end
    end
  end

  // R1
  ps_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (nxt_ps_o == $past(cur_s)) && !nxt_et_o);

  // R2
  cwp_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> nxt_cwp_o == (($past(cur_cwp) == '0) ? CWPW'(NWIN - 1) : $past(cur_cwp) - 1'b1));

  // R4
  vec_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> npc_o == pc_o + XLEN'(4));

  // R7
  async_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !trap_sync && !cur_et && !reset_req) |=> !take_o);

  // R8
  err_no_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_mode_o) |-> !take_o);

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_mode_o && !reset_req) |=> err_mode_o && !take_o);

  // R9
  pil_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> nxt_pil_o == $past(cur_pil));

  // R10
  reset_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> take_o && pc_o == '0 && !err_mode_o && !ex_commit_o);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> $stable(pc_o) && $stable(save0_o) && $stable(tbr_o));

endmodule

// File: tb/trap_entry_seq_test.sv
module trap_entry_seq_test;
  localparam int NWIN = 6;
  localparam int CW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic trap_req = 0, trap_sync = 0, reset_req = 0, cur_et = 0, cur_s = 0;
  logic [7:0]  trap_code = 0;
  logic [31:0] cur_pc = 0, cur_npc = 0;
  logic [CW-1:0] cur_cwp = 0;
  logic [3:0]  cur_pil = 0;
  logic [19:0] tbr_base = 0;

  logic take_o, err_mode_o, ex_commit_o, nxt_et_o, nxt_ps_o;
  logic [CW-1:0] nxt_cwp_o;
  logic [3:0] nxt_pil_o;
  logic [31:0] tbr_o, pc_o, npc_o, save0_o, save1_o;

  trap_entry_seq #(.NWIN(NWIN)) uut (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_sync(trap_sync),
    .trap_code(trap_code), .reset_req(reset_req), .cur_pc(cur_pc), .cur_npc(cur_npc),
    .cur_et(cur_et), .cur_s(cur_s), .cur_cwp(cur_cwp), .cur_pil(cur_pil),
    .tbr_base(tbr_base), .take_o(take_o), .err_mode_o(err_mode_o),
    .ex_commit_o(ex_commit_o), .nxt_et_o(nxt_et_o), .nxt_ps_o(nxt_ps_o),
    .nxt_cwp_o(nxt_cwp_o), .nxt_pil_o(nxt_pil_o), .tbr_o(tbr_o), .pc_o(pc_o),
    .npc_o(npc_o), .save0_o(save0_o), .save1_o(save1_o));

  int checks = 0, fails = 0;
  int e_take, e_err, e_commit, e_ps, e_cwp, e_pil;
  longint e_tbr, e_pc, e_npc, e_s0, e_s1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_take = 0; e_err = 0; e_commit = 0; e_ps = 0; e_cwp = 0; e_pil = 0;
      e_tbr = 0; e_pc = 0; e_npc = 0; e_s0 = 0; e_s1 = 0;
    end else begin
      e_take = 0;
      if (reset_req || (trap_req && cur_et && !e_err)) begin
        e_take = 1;
        e_ps = cur_s;
        e_cwp = (cur_cwp == 0) ? NWIN - 1 : int'(cur_cwp) - 1;
        e_pil = cur_pil;
        e_tbr = longint'(tbr_base) * 4096 + (reset_req ? 0 : longint'(trap_code) * 16);
        e_pc  = reset_req ? 0 : e_tbr;
        e_npc = (e_pc + 4) % 64'h1_0000_0000;
        if (reset_req || trap_sync) begin
          e_s0 = cur_pc; e_s1 = cur_npc; e_commit = 0;
        end else begin
          e_s0 = cur_npc; e_s1 = (longint'(cur_npc) + 4) % 64'h1_0000_0000; e_commit = 1;
        end
        if (reset_req) e_err = 0;
      end else if (trap_req && trap_sync && !cur_et && !e_err) begin
        e_err = 1;
      end
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R11 take", take_o, e_take);
    chk("R8 err_mode", err_mode_o, e_err);
    chk("R1 et cleared", nxt_et_o, 0);
    chk("R1 ps copy", nxt_ps_o, e_ps);
    chk("R2 cwp rotate", nxt_cwp_o, e_cwp);
    chk("R9 pil", nxt_pil_o, e_pil);
    chk("R3 tbr", tbr_o, e_tbr);
    chk("R4 pc", pc_o, e_pc);
    chk("R4 npc", npc_o, e_npc);
    chk("R5/R6 save0", save0_o, e_s0);
    chk("R5/R6 save1", save1_o, e_s1);
    chk("R6 commit", ex_commit_o, e_commit);
  endtask

  task automatic drive(input bit rq, input bit sy, input bit rs, input bit et, input int cwp);
    trap_req = rq; trap_sync = sy; reset_req = rs; cur_et = et;
    cur_cwp = CW'(cwp);
    cur_s = 1'($urandom); cur_pil = 4'($urandom);
    trap_code = 8'($urandom); tbr_base = 20'($urandom);
    cur_pc = $urandom & 32'hFFFF_FFFC;
    cur_npc = ($urandom % 4 == 0) ? 32'hFFFF_FFFC : cur_pc + 4;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: outputs cleared while rst_n low
    chk("R12 reset take", take_o, 0);
    chk("R12 reset pc", pc_o, 0);
    chk("R12 reset save0", save0_o, 0);
    rst_n = 1'b1;
    @(negedge clk); compare_all();
    // R2 wrap, R6 async entry with npc at top of address space
    drive(1, 0, 0, 1, 0); cur_npc = 32'hFFFF_FFFC;
    @(negedge clk); compare_all();
    // R7 async with ET=0 ignored, outputs hold
    drive(1, 0, 0, 0, 3);
    @(negedge clk); compare_all();
    // R8 sync with ET=0 enters error mode, then a valid trap is ignored
    drive(1, 1, 0, 0, 2);
    @(negedge clk); compare_all();
    drive(1, 1, 0, 1, 2);
    @(negedge clk); compare_all();
    // R10 reset while in error mode and with a trap request
    drive(1, 1, 1, 0, 5);
    @(negedge clk); compare_all();
    // R5 sync entry
    drive(1, 1, 0, 1, 4);
    @(negedge clk); compare_all();
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 2) == 0, ($urandom % 2) == 0, ($urandom % 25) == 0,
            ($urandom % 5) != 0, int'($urandom % NWIN));
      @(negedge clk); compare_all();
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule